// File: doc/BRIEF.md
# Instruction Operand Address Unit

This block performs the front half of an instruction cycle. It reads the instruction word at the instruction counter and advances the counter. It then shows the word to an external decoder and receives the decoder's class flags in return. From these it either throws the instruction away, if a skip was armed by the previous instruction, or works out the effective argument `N`. The argument is handed to the execute stage with a valid/ready handshake. The block then waits for the execute stage to report completion, and starts the next fetch.

Long-argument instructions take a base value from a register, or from a second memory word that follows the instruction. The pending pre-modifier is added to that base. A second register may then be added, and a single memory indirection may follow, in that fixed order. Short-argument instructions add a sign-extended immediate to the pre-modifier. The pre-modifier persists only across a modify instruction, and a small companion counter records how many modify instructions have been chained. Any memory fault wipes both the pre-modifier and the counter.

Instruction word fields used by the block: `C` = bits [2:0], `B` = bits [5:3], `D` = bit 6, immediate `T` = bits [6:0] (signed, 7 bits). For `C` and `B`, the value 0 means "no register". All other bits are opaque to the block.

Top module: `operand_addr_unit`

## Requirements
- R1: A fetch reads memory at the instruction counter and holds `mem_req` with a stable address until `mem_rvalid`. On a fault-free response the counter is incremented by one and `ir_valid` pulses for one cycle with the word on `ir_word`.
- R2: A faulted instruction fetch clears the pre-modifier and its counter. It leaves the instruction counter unchanged, delivers nothing, and the block fetches again.
- R3: When a skip is armed (set through `exe_skip` at `exe_done`), the next fetched instruction is not delivered and the skip is disarmed. The counter advances one extra word if that instruction is long-argument with `C`=0. The pre-modifier is left untouched.
- R4: For a long argument with `C`≠0, the base is `R[C]` plus the pre-modifier, and no argument word is read.
- R5: For a long argument with `C`=0, the word at the (already incremented) counter is read. The base is that word plus the pre-modifier, and the counter is incremented again.
- R6: For a long argument with `B`≠0, `R[B]` is added to the base modulo 2^16 after the base is formed.
- R7: For a long argument with `D`=1, `N` is replaced by the memory word at address `N`, after the `B` addition.
- R8: For a short argument, `N` is `T` sign-extended to 16 bits plus the pre-modifier, modulo 2^16.
- R9: An instruction with neither argument class is delivered with `N` = 0.
- R10: A faulted argument-word or indirect read delivers nothing, clears the pre-modifier and its counter, and starts the next fetch.
- R11: At `exe_done`, a modify instruction (`dec_md`) loads the pre-modifier from `exe_mod` and increments the counter (modulo 2^MODC_W). Any other instruction clears both. The pre-modifier does not change at any other time, except on a fault.
- R12: While `arg_valid` is high and `arg_ready` is low, `arg_valid` stays high and `arg_n` holds. `arg_valid` and `mem_req` are never high together.
- R13: After reset the counter is IC_RESET (0), the pre-modifier and its counter are 0, `arg_valid` is low, and a fetch at IC_RESET is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_rvalid | input | 1 | Read response this cycle |
| mem_fault | input | 1 | Response is a fault (qualified by `mem_rvalid`) |
| mem_rdata | input | 16 | Read data |
| rf_sel | output | 3 | Register file read index |
| rf_rdata | input | 16 | Register file read data (combinational) |
| ir_word | output | 16 | Last fetched instruction word |
| ir_valid | output | 1 | Decode strobe; flags are sampled in this cycle |
| dec_long | input | 1 | Instruction has a long argument |
| dec_short | input | 1 | Instruction has a short argument |
| dec_md | input | 1 | Instruction is the modify instruction |
| arg_valid | output | 1 | Argument valid to execute stage |
| arg_ready | input | 1 | Execute stage accepts argument |
| arg_n | output | 16 | Effective argument |
| exe_done | input | 1 | Execute stage finished the instruction |
| exe_skip | input | 1 | Arm skip of next instruction (with `exe_done`) |
| exe_mod | input | 16 | New pre-modifier value (with `exe_done`) |
| ic_out | output | 16 | Instruction counter |
| mod_out | output | 16 | Pending pre-modifier |
| modc_out | output | 4 | Chained modify counter |

## Verification
A stale or wrongly-cleared pre-modifier appears in `arg_n` on the very next delivered argument. It also shows on `mod_out` one cycle after the fault or completion that should have changed it. A counter that slips by a word shows at once in the address of the next fetch or argument read, and a lost skip flag appears as an extra delivery one fetch later. A wrong branch in the base/indirection order shows as a wrong `arg_n` or a missing or extra indirect read in the same instruction.

// File: rtl/oau_pkg.sv
// Shared definitions for the operand address unit.
// Assumes a fixed instruction-word layout for the three argument fields.
package oau_pkg;
    // Register index width (eight registers).
    localparam int RSEL_W = 3;
    // Field positions inside the instruction word.
    localparam int C_LSB = 0;
    localparam int B_LSB = 3;
    localparam int D_BIT = 6;
    localparam int T_W   = 7;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DEC,
        ST_ARG,
        ST_BASE,
        ST_IND,
        ST_OUT,
        ST_EXE
    } oau_state_e;
endpackage

// File: rtl/oau_mod_reg.sv
// Pre-modifier register with its chained-modify counter.
// Assumes clear and load are never requested in the same cycle; clear wins if they are.
module oau_mod_reg #(
    parameter int DW     = 16,
    parameter int MODC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic [DW-1:0]     load_val,
    output logic [DW-1:0]     mod_q,
    output logic [MODC_W-1:0] modc_q
);
    // Holds the modifier; cleared by faults or ordinary completions, loaded by modify.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            mod_q  <= '0;
            modc_q <= '0;
        end else if (load) begin
            mod_q  <= load_val;
            modc_q <= modc_q + 1'b1;
        end
    end
endmodule

// File: rtl/oau_seq.sv
// Cycle sequencer: fetch, skip handling, argument formation, delivery, completion.
// Assumes a combinational register file read and a memory port that may stall
// by withholding mem_rvalid while mem_req is held.
module oau_seq
    import oau_pkg::*;
#(
    parameter int          DW       = 16,
    parameter logic [DW-1:0] IC_RESET = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_req,
    output logic [DW-1:0]     mem_addr,
    input  logic              mem_rvalid,
    input  logic              mem_fault,
    input  logic [DW-1:0]     mem_rdata,
    output logic [RSEL_W-1:0] rf_sel,
    input  logic [DW-1:0]     rf_rdata,
    output logic [DW-1:0]     ir_word,
    output logic              ir_valid,
    input  logic              dec_long,
    input  logic              dec_short,
    input  logic              dec_md,
    output logic              arg_valid,
    input  logic              arg_ready,
    output logic [DW-1:0]     arg_n,
    input  logic              exe_done,
    input  logic              exe_skip,
    output logic [DW-1:0]     ic,
    input  logic [DW-1:0]     mod_val,
    output logic              mod_clr,
    output logic              mod_load
);
    oau_state_e          state_q;
    logic [DW-1:0]       ic_q;
    logic [DW-1:0]       n_q;
    logic [DW-1:0]       ir_q;
    logic                skip_q;
    logic                md_q;

    logic [RSEL_W-1:0]   c_fld;
    logic [RSEL_W-1:0]   b_fld;
    logic                d_bit;
    logic [DW-1:0]       t_ext;
    logic                rsp_ok;
    logic                rsp_bad;
    logic                finish;

    // Field extraction from the held instruction word.
    always_comb begin
        c_fld = ir_q[C_LSB +: RSEL_W];
        b_fld = ir_q[B_LSB +: RSEL_W];
        d_bit = ir_q[D_BIT];
        t_ext = {{(DW-T_W){ir_q[T_W-1]}}, ir_q[T_W-1:0]};
    end

    // Port-side decode of the current state.
    always_comb begin
        mem_req   = (state_q == ST_FETCH) || (state_q == ST_ARG) || (state_q == ST_IND);
        mem_addr  = (state_q == ST_IND) ? n_q : ic_q;
        rf_sel    = (state_q == ST_BASE) ? b_fld : c_fld;
        rsp_ok    = mem_req && mem_rvalid && !mem_fault;
        rsp_bad   = mem_req && mem_rvalid && mem_fault;
        finish    = (state_q == ST_EXE) && exe_done;
        mod_load  = finish && md_q;
        mod_clr   = rsp_bad || (finish && !md_q);
        ir_valid  = (state_q == ST_DEC);
        arg_valid = (state_q == ST_OUT);
        arg_n     = n_q;
        ir_word   = ir_q;
        ic        = ic_q;
    end

    // Main sequence: advances the counter, forms N and waits for completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
            ic_q    <= IC_RESET;
            n_q     <= '0;
            ir_q    <= '0;
            skip_q  <= 1'b0;
            md_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_FETCH: begin
                    if (rsp_ok) begin
                        ir_q    <= mem_rdata;
                        ic_q    <= ic_q + 1'b1;
                        state_q <= ST_DEC;
                    end
                end
                ST_DEC: begin
                    md_q <= dec_md;
                    if (skip_q) begin
                        skip_q  <= 1'b0;
                        if (dec_long && c_fld == '0) ic_q <= ic_q + 1'b1;
                        state_q <= ST_FETCH;
                    end else if (dec_long) begin
                        if (c_fld != '0) begin
                            n_q     <= rf_rdata + mod_val;
                            state_q <= ST_BASE;
                        end else begin
                            state_q <= ST_ARG;
                        end
                    end else if (dec_short) begin
                        n_q     <= t_ext + mod_val;
                        state_q <= ST_OUT;
                    end else begin
                        n_q     <= '0;
                        state_q <= ST_OUT;
                    end
                end
                ST_ARG: begin
                    if (rsp_bad) begin
                        state_q <= ST_FETCH;
                    end else if (rsp_ok) begin
                        n_q     <= mem_rdata + mod_val;
                        ic_q    <= ic_q + 1'b1;
                        state_q <= ST_BASE;
                    end
                end
                ST_BASE: begin
                    if (b_fld != '0) n_q <= n_q + rf_rdata;
                    state_q <= d_bit ? ST_IND : ST_OUT;
                end
                ST_IND: begin
                    if (rsp_bad) begin
                        state_q <= ST_FETCH;
                    end else if (rsp_ok) begin
                        n_q     <= mem_rdata;
                        state_q <= ST_OUT;
                    end
                end
                ST_OUT: begin
                    if (arg_ready) state_q <= ST_EXE;
                end
                ST_EXE: begin
                    if (exe_done) begin
                        skip_q  <= exe_skip;
                        state_q <= ST_FETCH;
                    end
                end
                default: state_q <= ST_FETCH;
            endcase
        end
    end
endmodule

// File: rtl/operand_addr_unit.sv
// Top of the operand address unit: sequencer plus pre-modifier register.
// Assumes one instruction in flight; execution happens outside between
// the argument handshake and exe_done.
module operand_addr_unit
    import oau_pkg::*;
#(
    parameter int            DW       = 16,
    parameter int            MODC_W   = 4,
    parameter logic [DW-1:0] IC_RESET = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_req,
    output logic [DW-1:0]     mem_addr,
    input  logic              mem_rvalid,
    input  logic              mem_fault,
    input  logic [DW-1:0]     mem_rdata,
    output logic [RSEL_W-1:0] rf_sel,
    input  logic [DW-1:0]     rf_rdata,
    output logic [DW-1:0]     ir_word,
    output logic              ir_valid,
    input  logic              dec_long,
    input  logic              dec_short,
    input  logic              dec_md,
    output logic              arg_valid,
    input  logic              arg_ready,
    output logic [DW-1:0]     arg_n,
    input  logic              exe_done,
    input  logic              exe_skip,
    input  logic [DW-1:0]     exe_mod,
    output logic [DW-1:0]     ic_out,
    output logic [DW-1:0]     mod_out,
    output logic [MODC_W-1:0] modc_out
);
    logic mod_clr;
    logic mod_load;

    oau_seq #(.DW(DW), .IC_RESET(IC_RESET)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_fault  (mem_fault),
        .mem_rdata  (mem_rdata),
        .rf_sel     (rf_sel),
        .rf_rdata   (rf_rdata),
        .ir_word    (ir_word),
        .ir_valid   (ir_valid),
        .dec_long   (dec_long),
        .dec_short  (dec_short),
        .dec_md     (dec_md),
        .arg_valid  (arg_valid),
        .arg_ready  (arg_ready),
        .arg_n      (arg_n),
        .exe_done   (exe_done),
        .exe_skip   (exe_skip),
        .ic         (ic_out),
        .mod_val    (mod_out),
        .mod_clr    (mod_clr),
        .mod_load   (mod_load)
    );

    oau_mod_reg #(.DW(DW), .MODC_W(MODC_W)) u_mod (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (mod_clr),
        .load     (mod_load),
        .load_val (exe_mod),
        .mod_q    (mod_out),
        .modc_q   (modc_out)
    );
endmodule

// File: rtl/oau_checker.sv
// Port-level protocol and state checks for operand_addr_unit, attached by bind.
module oau_checker #(
    parameter int DW     = 16,
    parameter int MODC_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic [DW-1:0]     mem_addr,
    input logic              mem_rvalid,
    input logic              mem_fault,
    input logic              ir_valid,
    input logic [DW-1:0]     ic_out,
    input logic              arg_valid,
    input logic              arg_ready,
    input logic [DW-1:0]     arg_n,
    input logic              exe_done,
    input logic [DW-1:0]     mod_out,
    input logic [MODC_W-1:0] modc_out
);
    logic rsp_bad;
    assign rsp_bad = mem_req && mem_rvalid && mem_fault;

    p_req_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    p_ic_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ir_valid |-> (ic_out == DW'($past(ic_out) + 1'b1)));

    // Covers R2 and R10: every faulted read wipes the modifier state.
    p_fault_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_bad |=> (mod_out == '0 && modc_out == '0));

    p_mod_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!rsp_bad && !exe_done) |=> ($stable(mod_out) && $stable(modc_out)));

    p_arg_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (arg_valid && !arg_ready) |=> (arg_valid && $stable(arg_n)));

    p_phase_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        arg_valid |-> !mem_req);
endmodule

bind operand_addr_unit oau_checker #(.DW(DW), .MODC_W(MODC_W)) u_oau_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .mem_fault  (mem_fault),
    .ir_valid   (ir_valid),
    .ic_out     (ic_out),
    .arg_valid  (arg_valid),
    .arg_ready  (arg_ready),
    .arg_n      (arg_n),
    .exe_done   (exe_done),
    .mod_out    (mod_out),
    .modc_out   (modc_out)
);

// File: tb/test_operand_addr_unit.sv
// Bench: memory, register file and decoder models driven by a reference of the
// requirements; directed corner cases followed by seeded random instructions.
module test_operand_addr_unit;
    localparam int DW        = 16;
    localparam int MODC_W    = 4;
    localparam int MEM_WORDS = 1024;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mem_req;
    logic [DW-1:0]     mem_addr;
    logic              mem_rvalid;
    logic              mem_fault;
    logic [DW-1:0]     mem_rdata;
    logic [2:0]        rf_sel;
    logic [DW-1:0]     rf_rdata;
    logic [DW-1:0]     ir_word;
    logic              ir_valid;
    logic              dec_long, dec_short, dec_md;
    logic              arg_valid;
    logic              arg_ready = 1'b0;
    logic [DW-1:0]     arg_n;
    logic              exe_done = 1'b0;
    logic              exe_skip = 1'b0;
    logic [DW-1:0]     exe_mod = '0;
    logic [DW-1:0]     ic_out;
    logic [DW-1:0]     mod_out;
    logic [MODC_W-1:0] modc_out;

    logic [DW-1:0] mem  [MEM_WORDS];
    logic [DW-1:0] regs [8];
    int  budget = 0;
    int  resp_idx = 0;
    int  fault_at = 0;
    bit  stall_en = 1'b0;
    logic stall = 1'b0;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    // Reference state.
    logic [DW-1:0]     m_ic;
    logic [DW-1:0]     m_mod;
    logic [MODC_W-1:0] m_modc;
    bit                m_p;

    always #5 clk = ~clk;

    operand_addr_unit #(.DW(DW), .MODC_W(MODC_W)) i_operand_addr_unit (
        .clk(clk), .rst_n(rst_n),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_fault(mem_fault), .mem_rdata(mem_rdata),
        .rf_sel(rf_sel), .rf_rdata(rf_rdata),
        .ir_word(ir_word), .ir_valid(ir_valid),
        .dec_long(dec_long), .dec_short(dec_short), .dec_md(dec_md),
        .arg_valid(arg_valid), .arg_ready(arg_ready), .arg_n(arg_n),
        .exe_done(exe_done), .exe_skip(exe_skip), .exe_mod(exe_mod),
        .ic_out(ic_out), .mod_out(mod_out), .modc_out(modc_out)
    );

    // Memory, register file and decoder models (bench opcode: [15:14] class, [13] modify).
    always_comb begin
        mem_rvalid = mem_req && (budget > 0) && !stall;
        mem_fault  = (int'(mem_addr) >= MEM_WORDS) || (resp_idx + 1 == fault_at);
        mem_rdata  = (int'(mem_addr) < MEM_WORDS) ? mem[mem_addr[9:0]] : '0;
        rf_rdata   = regs[rf_sel];
        dec_long   = (ir_word[15:14] == 2'b01);
        dec_short  = (ir_word[15:14] == 2'b10);
        dec_md     = ir_word[13];
    end

    always @(posedge clk) begin
        if (mem_req && mem_rvalid) begin
            budget   <= budget - 1;
            resp_idx <= resp_idx + 1;
        end
    end

    always @(negedge clk) stall <= stall_en && ($urandom_range(0, 3) == 0);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    task automatic wait_fetch(output bit timed_out);
        int t = 0;
        while (!(budget == 0 && mem_req) && t < 400) begin
            @(negedge clk);
            t++;
        end
        timed_out = (t >= 400);
    endtask

    // One instruction: place it, predict, run, compare at the ports.
    task automatic run_instr(input logic [15:0] ir, input logic [15:0] argw,
                             input int f_at, input bit xskip,
                             input logic [15:0] xmod, input string tag);
        bit islong = (ir[15:14] == 2'b01);
        bit isshort = (ir[15:14] == 2'b10);
        bit md = ir[13];
        logic [2:0] c = ir[2:0];
        logic [2:0] b = ir[5:3];
        bit d = ir[6];
        logic [15:0] sext = {{9{ir[6]}}, ir[6:0]};
        bit exp_del = 1'b0;
        bit faulted = 1'b0;
        int exp_resp = 1;
        logic [15:0] exp_n = '0;
        logic [15:0] ic0 = m_ic;
        int t = 0;
        bit to;
        string mreq;

        mem[ic0[9:0]] = ir;
        if (int'(ic0) + 1 < MEM_WORDS) mem[ic0[9:0] + 10'd1] = argw;

        if (f_at == 1) begin
            faulted = 1'b1;
        end else begin
            m_ic = m_ic + 1'b1;
            if (m_p) begin
                m_p = 1'b0;
                if (islong && c == 3'd0) m_ic = m_ic + 1'b1;
            end else begin
                exp_del = 1'b1;
                if (islong) begin
                    if (c != 3'd0) begin
                        exp_n = regs[c] + m_mod;
                    end else begin
                        exp_resp = 2;
                        if (f_at == 2) faulted = 1'b1;
                        else begin
                            exp_n = mem[m_ic[9:0]] + m_mod;
                            m_ic = m_ic + 1'b1;
                        end
                    end
                    if (!faulted) begin
                        if (b != 3'd0) exp_n = exp_n + regs[b];
                        if (d) begin
                            exp_resp++;
                            if (int'(exp_n) >= MEM_WORDS || f_at == exp_resp) faulted = 1'b1;
                            else exp_n = mem[exp_n[9:0]];
                        end
                    end
                end else if (isshort) begin
                    exp_n = sext + m_mod;
                end
            end
        end
        if (faulted) begin
            exp_del = 1'b0;
            m_mod = '0;
            m_modc = '0;
        end
        mreq = faulted ? ((f_at == 1) ? "R2" : "R10") : "R11";

        fault_at = f_at;
        resp_idx = 0;
        budget = exp_resp;

        while (!(arg_valid || (budget == 0 && mem_req)) && t < 400) begin
            @(negedge clk);
            t++;
        end
        chk(t < 400, tag, "progress", 32'(t), 32'd0);
        chk(arg_valid == exp_del, exp_del ? tag : (m_p ? tag : "R3"), "delivery",
            32'(arg_valid), 32'(exp_del));

        if (arg_valid) begin
            logic [15:0] held;
            int hold;
            chk(arg_n == exp_n, tag, "arg_n", 32'(arg_n), 32'(exp_n));
            chk(ic_out == m_ic, "R1", "ic at delivery", 32'(ic_out), 32'(m_ic));
            held = arg_n;
            hold = $urandom_range(0, 2);
            repeat (hold) @(negedge clk);
            if (hold > 0)
                chk(arg_valid && arg_n == held, "R12", "held argument", 32'(arg_n), 32'(held));
            arg_ready = 1'b1;
            @(negedge clk);
            arg_ready = 1'b0;
            repeat ($urandom_range(0, 2)) @(negedge clk);
            exe_done = 1'b1;
            exe_skip = xskip;
            exe_mod  = xmod;
            @(negedge clk);
            exe_done = 1'b0;
            exe_skip = 1'b0;
            if (md) begin
                m_mod = xmod;
                m_modc = m_modc + 1'b1;
            end else begin
                m_mod = '0;
                m_modc = '0;
            end
            m_p = xskip;
            wait_fetch(to);
            chk(!to, "R11", "return to fetch", 32'(to), 32'd0);
        end

        chk(ic_out == m_ic && mem_addr == m_ic, "R1", "next fetch address",
            32'(mem_addr), 32'(m_ic));
        chk(mod_out == m_mod, mreq, "mod_out", 32'(mod_out), 32'(m_mod));
        chk(modc_out == m_modc, mreq, "modc_out", 32'(modc_out), 32'(m_modc));
    endtask

    // Random register file with a bias towards small values so indirection can succeed.
    task automatic rand_regs();
        for (int i = 0; i < 8; i++)
            regs[i] = ($urandom_range(0, 1) == 1) ? 16'($urandom_range(0, 300)) : 16'($urandom);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        for (int i = 0; i < MEM_WORDS; i++) mem[i] = '0;
        for (int i = 0; i < 8; i++) regs[i] = '0;
        m_ic = '0; m_mod = '0; m_modc = '0; m_p = 1'b0;

        repeat (3) @(negedge clk);
        // R13: reset state.
        chk(ic_out == 16'd0, "R13", "ic after reset", 32'(ic_out), 32'd0);
        chk(mod_out == 16'd0 && modc_out == '0, "R13", "mod after reset", 32'(mod_out), 32'd0);
        chk(!arg_valid, "R13", "arg_valid after reset", 32'(arg_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_req && mem_addr == 16'd0, "R13", "first fetch", 32'(mem_addr), 32'd0);

        // R4: register base.
        regs[3] = 16'h1234;
        run_instr({2'b01, 1'b0, 6'd0, 1'b0, 3'd0, 3'd3}, 16'h0, 0, 1'b0, 16'h0, "R4");
        // R9 and R11: modify chain.
        run_instr({2'b00, 1'b1, 13'd0}, 16'h0, 0, 1'b0, 16'h0010, "R9");
        run_instr({2'b00, 1'b1, 13'd0}, 16'h0, 0, 1'b0, 16'h0020, "R11");
        // R5 and R6: argument word plus modifier plus base register.
        regs[2] = 16'h0005;
        run_instr({2'b01, 1'b0, 6'd0, 1'b0, 3'd2, 3'd0}, 16'h0100, 0, 1'b0, 16'h0, "R6");
        run_instr({2'b01, 1'b0, 6'd0, 1'b0, 3'd0, 3'd0}, 16'h0777, 0, 1'b0, 16'h0, "R5");
        // R8: negative immediate, then arm a skip.
        run_instr({2'b10, 1'b0, 6'd0, 7'h7F}, 16'h0, 0, 1'b1, 16'h0, "R8");
        // R3: skipped long instruction with an argument word.
        run_instr({2'b01, 1'b0, 6'd0, 1'b0, 3'd0, 3'd0}, 16'h0, 0, 1'b0, 16'h0, "R3");
        // R7: indirection through a known word.
        mem[10'h300] = 16'hBEEF;
        run_instr({2'b01, 1'b0, 6'd0, 1'b1, 3'd0, 3'd0}, 16'h0300, 0, 1'b0, 16'h0, "R7");
        // R2: fetch fault after building a modifier.
        run_instr({2'b00, 1'b1, 13'd0}, 16'h0, 0, 1'b0, 16'h0042, "R11");
        run_instr({2'b01, 1'b0, 13'd0}, 16'h0, 1, 1'b0, 16'h0, "R2");
        // R10: argument word fault and indirect fault.
        run_instr({2'b00, 1'b1, 13'd0}, 16'h0, 0, 1'b0, 16'h0042, "R11");
        run_instr({2'b01, 1'b0, 6'd0, 1'b0, 3'd0, 3'd0}, 16'h0, 2, 1'b0, 16'h0, "R10");
        regs[1] = 16'hF000;
        run_instr({2'b01, 1'b0, 6'd0, 1'b1, 3'd0, 3'd1}, 16'h0, 0, 1'b0, 16'h0, "R10");
        // R3: skipped short instruction, modifier kept across it.
        run_instr({2'b00, 1'b1, 13'd0}, 16'h0, 0, 1'b1, 16'h0033, "R11");
        run_instr({2'b10, 1'b0, 13'd5}, 16'h0, 0, 1'b0, 16'h0, "R3");
        run_instr({2'b10, 1'b0, 13'd5}, 16'h0, 0, 1'b0, 16'h0, "R8");

        // Random phase with memory stalls.
        stall_en = 1'b1;
        for (int k = 0; k < 250; k++) begin
            logic [15:0] ir;
            logic [15:0] aw;
            int fa;
            rand_regs();
            ir = 16'($urandom);
            ir[15:14] = 2'($urandom_range(0, 2));
            ir[13] = ($urandom_range(0, 4) == 0);
            aw = ($urandom_range(0, 1) == 1) ? 16'($urandom_range(0, 400)) : 16'($urandom);
            fa = ($urandom_range(0, 9) == 0) ? $urandom_range(1, 3) : 0;
            run_instr(ir, aw, fa, ($urandom_range(0, 6) == 0),
                      16'($urandom_range(0, 200)), "R4");
        end

        finish_run();
    end
endmodule